// File: doc/BRIEF.md
# Register Command Bus Executor

This block sits behind a frame decryptor and turns one plaintext configuration frame into one bus transaction. The incoming byte stream still carries the 14-byte Ethernet header (destination MAC, source MAC, Ethertype). The decrypted command follows directly after it, because the channel, reserved and IV fields have already been stripped. The block decodes a read or a write command and runs it as a single Wishbone classic cycle on its master port. It then emits a fixed-length response frame for the encryptor to protect and transmit.

Frame byte positions used by the block, with multi-byte fields big-endian:

- bytes 0..5: destination MAC
- bytes 6..11: source MAC
- bytes 12..13: Ethertype
- byte 14: opcode
- bytes 15..16: register address
- bytes 17..20: write data (write commands only)

Bytes after the command are padding and are discarded. The response is always 22 bytes long:

- bytes 0..5: the incoming source MAC
- bytes 6..11: the incoming destination MAC
- bytes 12..13: the Ethertype
- byte 14: the opcode echoed
- byte 15: a status code
- bytes 16..17: the address echoed
- bytes 18..21: a 32-bit result

Input is accepted only while the block is idle. Output follows a valid/ready handshake. A new frame is taken only after the last response byte has been accepted.

Top module: `cmd_bus_executor`

## Requirements
- R1: After reset the block is idle: `in_ready` is 1, `out_valid` is 0 and `wb_cyc` is 0.
- R2: Opcode 0x52 (read) starts one Wishbone cycle with `wb_we`=0 and `wb_adr` = {byte15, byte16}. The response carries status 0x00 and, in bytes 18..21, the `wb_dat_i` word sampled with `wb_ack`, most significant byte first.
- R3: Opcode 0x57 (write) starts one Wishbone cycle with `wb_we`=1 and `wb_dat_o` = bytes 17..20 (byte 17 most significant). The response carries status 0x00 and echoes the written word in bytes 18..21.
- R4: Every response is exactly 22 bytes, with `out_last` set only on byte 21. The MAC addresses are swapped, and the Ethertype, opcode (byte 14) and address (bytes 16..17) are copied.
- R5: Any opcode other than 0x52 or 0x57 starts no bus cycle. Its response carries status 0x01 and a zero result.
- R6: If `wb_ack` is not seen within TIMEOUT (default 256) clocks of `wb_cyc` high, the cycle ends after exactly TIMEOUT clocks. The response then carries status 0x02 and a zero result. An ack in the last of those clocks still completes with status 0x00.
- R7: A frame that ends before its command is complete starts no bus cycle and returns status 0x03. Fields that were not received read as zero in the response. This includes frames too short to hold an opcode.
- R8: Bytes after the end of the command are ignored. They change neither the bus cycle nor the response, and the next frame is decoded from its own first byte.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold. `in_ready` stays 0 from the last input byte until the last response byte is accepted.
- R10: During a bus cycle `wb_stb` equals `wb_cyc`, and address, write enable and write data stay stable. `wb_cyc` falls in the clock after the one in which `wb_ack` is sampled, so a cycle acked after d extra clocks lasts d+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Marks the last byte of the input frame |
| in_ready | output | 1 | Block accepts input bytes |
| out_valid | output | 1 | Response byte valid |
| out_data | output | 8 | Response frame byte |
| out_last | output | 1 | Marks the last response byte |
| out_ready | input | 1 | Downstream accepts the response byte |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | 16 | Wishbone address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |

## Verification
Reads and writes are run with distinct address and data bytes and with both immediate and delayed acks. These runs show that byte order, field positions and the read/write choice are decoded correctly, and that cycle length tracks the ack. Unknown opcodes and frames cut short at several lengths show that error paths never touch the bus and still answer with the correct status. Two cases sit on either side of the timeout limit: an ack on the final allowed clock, and no ack at all. A padded write followed at once by a read confirms that trailing bytes are dropped and that the next frame starts cleanly. A stalled receiver confirms that response bytes hold while `out_ready` is low.

// File: rtl/cmd_bus_executor.sv
module cmd_bus_executor #(
  parameter int TIMEOUT = 256,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [7:0] OP_RD = 8'h52,
  parameter logic [7:0] OP_WR = 8'h57
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [ADDR_W-1:0] wb_adr,
  output logic [DATA_W-1:0] wb_dat_o,
  input  logic [DATA_W-1:0] wb_dat_i,
  input  logic              wb_ack
);
  localparam int AB      = ADDR_W / 8;
  localparam int DB      = DATA_W / 8;
  localparam int OP_POS  = 14;
  localparam int ADR_POS = OP_POS + 1;
  localparam int DAT_POS = ADR_POS + AB;
  localparam int FRM_MAX = DAT_POS + DB;
  localparam int RSP_LEN = OP_POS + 2 + AB + DB;
  localparam int CW      = $clog2(RSP_LEN + 1);
  localparam int TW      = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  localparam logic [CW-1:0] L_OP   = CW'(OP_POS);
  localparam logic [CW-1:0] L_DAT  = CW'(DAT_POS);
  localparam logic [CW-1:0] L_MAX  = CW'(FRM_MAX);
  localparam logic [CW-1:0] L_LAST = CW'(RSP_LEN - 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);

  localparam logic [7:0] ST_OK    = 8'h00;
  localparam logic [7:0] ST_BADOP = 8'h01;
  localparam logic [7:0] ST_TMO   = 8'h02;
  localparam logic [7:0] ST_SHORT = 8'h03;

  typedef enum logic [1:0] {S_RX, S_DEC, S_BUS, S_TX} st_t;

  st_t             st;
  logic [7:0]      fb [FRM_MAX];
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   idx;
  logic [TW-1:0]   tmr;
  logic [7:0]      status;
  logic [DATA_W-1:0] rdat;
  logic [7:0]      rsp_byte;

  assign in_ready  = (st == S_RX);
  assign out_valid = (st == S_TX);
  assign out_last  = out_valid && (idx == L_LAST);
  assign out_data  = rsp_byte;
  assign wb_cyc    = (st == S_BUS);
  assign wb_stb    = wb_cyc;
  assign wb_we     = (fb[OP_POS] == OP_WR);

  always_comb begin
    for (int i = 0; i < AB; i++) wb_adr[8*(AB-1-i) +: 8] = fb[ADR_POS+i];
    for (int i = 0; i < DB; i++) wb_dat_o[8*(DB-1-i) +: 8] = fb[DAT_POS+i];
  end

  always_comb begin
    int k;
    rsp_byte = 8'h00;
    k = int'(idx);
    if (k < 6)                 rsp_byte = fb[k+6];
    else if (k < 12)           rsp_byte = fb[k-6];
    else if (k < OP_POS + 1)   rsp_byte = fb[k];
    else if (k == OP_POS + 1)  rsp_byte = status;
    else if (k < OP_POS + 2 + AB) rsp_byte = fb[ADR_POS + k - (OP_POS + 2)];
    else if (k < RSP_LEN)      rsp_byte = 8'(rdat >> (8*(DB - 1 - (k - (OP_POS + 2 + AB)))));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_RX;
      cnt    <= '0;
      idx    <= '0;
      tmr    <= '0;
      status <= ST_OK;
      rdat   <= '0;
      for (int i = 0; i < FRM_MAX; i++) fb[i] <= 8'h00;
    end else begin
      case (st)
        S_RX: if (in_valid) begin
          if (cnt < L_MAX) begin
            fb[cnt] <= in_data;
            cnt <= cnt + 1'b1;
          end
          if (in_last) st <= S_DEC;
        end
        S_DEC: begin
          idx  <= '0;
          tmr  <= '0;
          rdat <= '0;
          if (cnt <= L_OP) begin
            status <= ST_SHORT;
            st <= S_TX;
          end else if (fb[OP_POS] == OP_RD) begin
            if (cnt < L_DAT) begin
              status <= ST_SHORT;
              st <= S_TX;
            end else st <= S_BUS;
          end else if (fb[OP_POS] == OP_WR) begin
            if (cnt < L_MAX) begin
              status <= ST_SHORT;
              st <= S_TX;
            end else st <= S_BUS;
          end else begin
            status <= ST_BADOP;
            st <= S_TX;
          end
        end
        S_BUS: begin
          if (wb_ack) begin
            rdat   <= wb_we ? wb_dat_o : wb_dat_i;
            status <= ST_OK;
            st     <= S_TX;
          end else if (tmr == T_LAST) begin
            status <= ST_TMO;
            st     <= S_TX;
          end else tmr <= tmr + 1'b1;
        end
        S_TX: if (out_ready) begin
          if (idx == L_LAST) begin
            st  <= S_RX;
            cnt <= '0;
            for (int i = 0; i < FRM_MAX; i++) fb[i] <= 8'h00;
          end else idx <= idx + 1'b1;
        end
        default: st <= S_RX;
      endcase
    end
  end

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && !wb_ack && tmr != T_LAST |=> wb_cyc && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dat_o));

  assert_drop_on_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && wb_ack |=> !wb_cyc && out_valid);

  assert_timeout_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc && !wb_ack && tmr == T_LAST |=> !wb_cyc && out_valid);

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_idle_after_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready && !out_valid);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({in_ready, out_valid, wb_cyc}) <= 1);
endmodule

// File: tb/test_cmd_bus_executor.sv
module test_cmd_bus_executor;
  localparam int RSP = 22;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, in_last = 0, out_ready = 0;
  logic [7:0]  in_data = 0;
  logic        in_ready, out_valid, out_last;
  logic [7:0]  out_data;
  logic        wb_cyc, wb_stb, wb_we, wb_ack = 0;
  logic [15:0] wb_adr;
  logic [31:0] wb_dat_o, wb_dat_i = 0;

  cmd_bus_executor i_cmd_bus_executor (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack)
  );

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [7:0] frm [32];
  int flen;
  logic [7:0] rsp [RSP];
  int ack_dly = 0;
  logic [31:0] slv_rdata = 0;
  int bus_cnt = 0, cyc_len = 0, stab_err = 0;
  logic prev_cyc = 0;
  logic [15:0] seen_adr;
  logic        seen_we;
  logic [31:0] seen_dat;
  int saw_inready = 0;

  task automatic cmp(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    wb_ack = 0;
    if (wb_cyc) begin
      if (!prev_cyc) begin
        bus_cnt++;
        cyc_len = 0;
        seen_adr = wb_adr;
        seen_we = wb_we;
        seen_dat = wb_dat_o;
      end else if (wb_adr !== seen_adr || wb_we !== seen_we || wb_dat_o !== seen_dat || wb_stb !== 1'b1)
        stab_err++;
      cyc_len++;
      if (ack_dly >= 0 && cyc_len == ack_dly + 1) begin
        wb_ack = 1;
        wb_dat_i = slv_rdata;
      end
    end
    prev_cyc = wb_cyc;
  end

  task automatic mk(input logic [7:0] op, input logic [15:0] adr, input logic [31:0] dat, input int len);
    for (int i = 0; i < 32; i++) frm[i] = 8'hEE;
    for (int i = 0; i < 6; i++) begin
      frm[i] = 8'hA0 + 8'(i);
      frm[6+i] = 8'hB0 + 8'(i);
    end
    frm[12] = 8'h88; frm[13] = 8'hB5; frm[14] = op;
    frm[15] = adr[15:8]; frm[16] = adr[7:0];
    frm[17] = dat[31:24]; frm[18] = dat[23:16]; frm[19] = dat[15:8]; frm[20] = dat[7:0];
    flen = len;
  endtask

  function automatic logic [7:0] fv(input int j);
    return (j < flen && j < 21) ? frm[j] : 8'h00;
  endfunction

  task automatic send();
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_data = frm[i]; in_last = (i == flen - 1);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic recv(input bit bp);
    int n = 0, g = 0;
    bit stalled = 0;
    logic [7:0] hold = 0;
    saw_inready = 0;
    out_ready = !bp;
    while (n < RSP && g < 5000) begin
      @(negedge clk); g++;
      if (out_valid) begin
        if (in_ready) saw_inready++;
        if (bp && !stalled) begin
          out_ready = 0; hold = out_data; stalled = 1;
        end else begin
          if (bp) cmp("R9", "held byte under stall", {24'h0, out_data}, {24'h0, hold});
          cmp("R4", "out_last position", {31'h0, out_last}, {31'h0, (n == RSP - 1)});
          rsp[n] = out_data; n++;
          out_ready = 1; stalled = 0;
        end
      end
    end
    cmp("R4", "response byte count", n, RSP);
    cmp("R9", "in_ready during reply", saw_inready, 0);
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic chk_rsp(input string req, input logic [7:0] st, input logic [31:0] data);
    for (int i = 0; i < 6; i++) begin
      cmp("R4", "dst from src", {24'h0, rsp[i]}, {24'h0, fv(6+i)});
      cmp("R4", "src from dst", {24'h0, rsp[6+i]}, {24'h0, fv(i)});
    end
    cmp("R4", "ethertype", {rsp[12], rsp[13]}, {fv(12), fv(13)});
    cmp("R4", "opcode echo", {24'h0, rsp[14]}, {24'h0, fv(14)});
    cmp(req, "status", {24'h0, rsp[15]}, {24'h0, st});
    cmp("R4", "address echo", {rsp[16], rsp[17]}, {fv(15), fv(16)});
    cmp(req, "result word", {rsp[18], rsp[19], rsp[20], rsp[21]}, data);
  endtask

  task automatic t_reset();
    cmp("R1", "in_ready after reset", {31'h0, in_ready}, 1);
    cmp("R1", "out_valid after reset", {31'h0, out_valid}, 0);
    cmp("R1", "wb_cyc after reset", {31'h0, wb_cyc}, 0);
  endtask

  task automatic t_read();
    int b0 = bus_cnt;
    mk(8'h52, 16'h1234, 32'h0, 17);
    slv_rdata = 32'hDEADBEEF; ack_dly = 2; stab_err = 0;
    send(); recv(0);
    cmp("R2", "one bus cycle", bus_cnt - b0, 1);
    cmp("R2", "read address", {16'h0, seen_adr}, 32'h1234);
    cmp("R2", "read we", {31'h0, seen_we}, 0);
    cmp("R10", "cycle length with delayed ack", cyc_len, 3);
    cmp("R10", "stable bus signals", stab_err, 0);
    chk_rsp("R2", 8'h00, 32'hDEADBEEF);
  endtask

  task automatic t_write();
    int b0 = bus_cnt;
    mk(8'h57, 16'hA55A, 32'h01020304, 21);
    ack_dly = 0; stab_err = 0;
    send(); recv(1);
    cmp("R3", "one bus cycle", bus_cnt - b0, 1);
    cmp("R3", "write address", {16'h0, seen_adr}, 32'hA55A);
    cmp("R3", "write we", {31'h0, seen_we}, 1);
    cmp("R3", "write data", seen_dat, 32'h01020304);
    cmp("R10", "cycle length with immediate ack", cyc_len, 1);
    chk_rsp("R3", 8'h00, 32'h01020304);
  endtask

  task automatic t_badop();
    int b0 = bus_cnt;
    mk(8'h41, 16'h0F0F, 32'h11223344, 21);
    send(); recv(0);
    cmp("R5", "no bus cycle", bus_cnt - b0, 0);
    chk_rsp("R5", 8'h01, 32'h0);
  endtask

  task automatic t_timeout();
    int b0 = bus_cnt;
    mk(8'h52, 16'h0042, 32'h0, 17);
    ack_dly = -1; slv_rdata = 32'hCAFEF00D;
    send(); recv(0);
    cmp("R6", "one bus cycle", bus_cnt - b0, 1);
    cmp("R6", "cycle ends at limit", cyc_len, 256);
    chk_rsp("R6", 8'h02, 32'h0);
  endtask

  task automatic t_ack_edge();
    mk(8'h52, 16'h0043, 32'h0, 17);
    ack_dly = 255; slv_rdata = 32'h5A5AA5A5;
    send(); recv(0);
    cmp("R6", "ack on last clock length", cyc_len, 256);
    chk_rsp("R6", 8'h00, 32'h5A5AA5A5);
  endtask

  task automatic t_short();
    int b0 = bus_cnt;
    ack_dly = 0;
    mk(8'h57, 16'hBEEF, 32'h99887766, 18);
    send(); recv(0);
    chk_rsp("R7", 8'h03, 32'h0);
    mk(8'h52, 16'hC3D4, 32'h0, 16);
    send(); recv(0);
    chk_rsp("R7", 8'h03, 32'h0);
    cmp("R7", "short read address low byte zero", {24'h0, rsp[17]}, 0);
    mk(8'h52, 16'h0001, 32'h0, 10);
    send(); recv(0);
    chk_rsp("R7", 8'h03, 32'h0);
    cmp("R7", "no bus cycle on short frames", bus_cnt - b0, 0);
  endtask

  task automatic t_pad();
    int b0 = bus_cnt;
    ack_dly = 1;
    mk(8'h57, 16'h7001, 32'hFACE0FF0, 30);
    send(); recv(0);
    cmp("R8", "padded write data", seen_dat, 32'hFACE0FF0);
    cmp("R8", "padded write address", {16'h0, seen_adr}, 32'h7001);
    chk_rsp("R8", 8'h00, 32'hFACE0FF0);
    mk(8'h52, 16'h7002, 32'h0, 17);
    slv_rdata = 32'h0BADC0DE;
    send(); recv(0);
    cmp("R8", "next frame address", {16'h0, seen_adr}, 32'h7002);
    chk_rsp("R8", 8'h00, 32'h0BADC0DE);
    cmp("R8", "two bus cycles", bus_cnt - b0, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_badop();
    t_timeout();
    t_ack_edge();
    t_short();
    t_pad();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule